// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit processor with a 16-bit address bus and a large banked ROM with an optional battery-backed RAM. The lower half of the processor map is read-only program space. Writes into that half do not reach the ROM. They are decoded as updates to four small control registers: a RAM enable flag, a 5-bit primary ROM bank, a 2-bit secondary bank and a banking mode bit.

On every access the block works out the 21-bit physical ROM address and the 15-bit external RAM address. It also gates the external RAM. While RAM is off, reads in the RAM window return 0xFF and writes there are dropped.

The ROM size and the RAM size are static configuration inputs. The storage arrays are outside the block: the ROM and RAM bytes come back on `rom_rdata` and `ram_rdata`, and the block picks which one reaches the processor.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the primary bank is 1, the secondary bank is 0, the mode is 0 and RAM is disabled. So a read of 0x4000 maps to physical ROM address 0x004000, and a read in 0xA000–0xBFFF returns 0xFF.
- R2: A write strobe with address 0x0000–0x1FFF enables RAM if bits [3:0] of the byte equal 0xA. Any other value disables RAM. Register updates take effect on the clock edge that samples the strobe.
- R3: A write to 0x2000–0x3FFF loads the primary bank. If byte[4:0] is zero the bank becomes 1. Otherwise the bank becomes byte[4:0] AND mask[4:0]. The zero test uses the raw value before masking, so the stored bank can end up as 0.
- R4: A write to 0x4000–0x5FFF loads byte[1:0] into the secondary bank. A write to 0x6000–0x7FFF loads byte[0] into the mode bit.
- R5: The ROM mask is 2^`cfg_rom_log2` − 1, for `cfg_rom_log2` from 1 to 7. A value of 0 is treated as 1. A bank field placed on `rom_addr[20:14]` never has bits set outside the mask.
- R6: A read of 0x0000–0x3FFF maps to `rom_addr` = CPU address when mode is 0. When mode is 1 it maps to 0x4000 × ((secondary << 5) AND mask) + CPU address.
- R7: A read of 0x4000–0x7FFF maps to `rom_addr` = 0x4000 × (((secondary << 5) OR primary) AND mask) + (CPU address − 0x4000).
- R8: In the window 0xA000–0xBFFF, `cpu_rdata` shows `ram_rdata` and `ram_we` follows `cpu_wr` while RAM is enabled. While RAM is disabled, `cpu_rdata` is 0xFF and `ram_we` stays low.
- R9: With `cfg_ram_size` = 2 (32 KiB) and mode 1, `ram_addr` = 0x2000 × secondary + (CPU address − 0xA000). With mode 0, `ram_addr` is the offset from 0xA000.
- R10: With `cfg_ram_size` = 0 (none) or 1 (8 KiB), `ram_addr` is the offset from 0xA000 modulo 8 KiB, so bits [14:13] are zero whatever the mode.
- R11: Control registers change only on a write strobe with address below 0x8000. Outside the RAM window, `cpu_rdata` shows `rom_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_wr | input | 1 | Processor write strobe |
| rom_rdata | input | 8 | Byte returned by the ROM at `rom_addr` |
| ram_rdata | input | 8 | Byte returned by the RAM at `ram_addr` |
| cfg_rom_log2 | input | 3 | log2 of the ROM bank count (1..7) |
| cfg_ram_size | input | 2 | 0 none, 1 8 KiB, 2 32 KiB |
| cpu_rdata | output | 8 | Read data to the processor |
| rom_addr | output | 21 | Physical ROM address |
| ram_addr | output | 15 | External RAM address |
| ram_we | output | 1 | External RAM write enable |

## Verification
The bench writes a bank value whose low five bits are zero but whose upper bits are set (0x20). A design that tested the whole byte, or tested after masking, would keep a stale or zero bank instead of selecting bank 1. With a 4-bank mask the bench writes 0x04: the correct result is bank 0, and a design that re-applied the zero substitution after masking would point at bank 1. The bench toggles the mode to move the secondary bits between the lower ROM window and the RAM bank, and changes the ROM size so that masking of the lower-window bank shows up. It also enables RAM with a byte whose upper nibble is nonzero (0x1A), and it writes into the RAM window while RAM is disabled. These catch a comparison on the full byte and a write enable that leaks through the gate.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int CPU_AW    = 16;
  localparam int DW        = 8;
  localparam int PRI_W     = 5;
  localparam int SEC_W     = 2;
  localparam int BANK_W    = PRI_W + SEC_W;
  localparam int OFS_W     = 14;
  localparam int ROM_AW    = BANK_W + OFS_W;
  localparam int RAM_OFS_W = 13;
  localparam int RAM_AW    = RAM_OFS_W + SEC_W;
  localparam int LOG2_W    = 3;

  typedef enum logic [1:0] {
    RAM_NONE = 2'd0,
    RAM_8K   = 2'd1,
    RAM_32K  = 2'd2,
    RAM_RSVD = 2'd3
  } ram_cfg_e;

  typedef struct packed {
    logic             ram_en;
    logic             mode;
    logic [SEC_W-1:0] sec;
    logic [PRI_W-1:0] pri;
  } bank_regs_t;

  // bank-count mask, at least two banks
  function automatic logic [BANK_W-1:0] rom_mask(input logic [LOG2_W-1:0] lg);
    logic [LOG2_W-1:0] eff;
    logic [BANK_W:0]   full;
    eff  = (lg == '0) ? LOG2_W'(1) : lg;
    full = ((BANK_W+1)'(1) << eff) - (BANK_W+1)'(1);
    return full[BANK_W-1:0];
  endfunction

  // zero substitution decided on the raw field, mask applied afterwards
  function automatic logic [PRI_W-1:0] next_primary(input logic [DW-1:0] b,
                                                    input logic [BANK_W-1:0] m);
    if (b[PRI_W-1:0] == '0) return PRI_W'(1);
    return b[PRI_W-1:0] & m[PRI_W-1:0];
  endfunction

  function automatic logic [BANK_W-1:0] low_window_bank(input logic [SEC_W-1:0] s,
                                                       input logic [BANK_W-1:0] m);
    return {s, {PRI_W{1'b0}}} & m;
  endfunction

  function automatic logic [BANK_W-1:0] high_window_bank(input logic [SEC_W-1:0] s,
                                                        input logic [PRI_W-1:0] p,
                                                        input logic [BANK_W-1:0] m);
    return {s, p} & m;
  endfunction
endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
  import cbc_pkg::*;
(
  input  logic [CPU_AW-1:0] addr,
  output logic              hit_en,
  output logic              hit_pri,
  output logic              hit_sec,
  output logic              hit_mode,
  output logic              hit_rom_lo,
  output logic              hit_rom_hi,
  output logic              hit_ram
);
  localparam int TOP_W = 3;
  logic [TOP_W-1:0] top;
  assign top = addr[CPU_AW-1 -: TOP_W];

  always_comb begin
    hit_en   = (top == 3'd0);
    hit_pri  = (top == 3'd1);
    hit_sec  = (top == 3'd2);
    hit_mode = (top == 3'd3);
    hit_ram  = (top == 3'd5);
  end

  assign hit_rom_lo = (addr[CPU_AW-1 -: 2] == 2'b00);
  assign hit_rom_hi = (addr[CPU_AW-1 -: 2] == 2'b01);
endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              hit_en,
  input  logic              hit_pri,
  input  logic              hit_sec,
  input  logic              hit_mode,
  input  logic [DW-1:0]     wdata,
  input  logic [BANK_W-1:0] mask,
  output bank_regs_t        regs_q
);
  localparam logic [3:0] EN_KEY = 4'hA;
  bank_regs_t regs_d;

  always_comb begin
    regs_d = regs_q;
    if (wr) begin
      if (hit_en)   regs_d.ram_en = (wdata[3:0] == EN_KEY);
      if (hit_pri)  regs_d.pri    = next_primary(wdata, mask);
      if (hit_sec)  regs_d.sec    = wdata[SEC_W-1:0];
      if (hit_mode) regs_d.mode   = wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q.ram_en <= 1'b0;
      regs_q.mode   <= 1'b0;
      regs_q.sec    <= '0;
      regs_q.pri    <= PRI_W'(1);
    end else begin
      regs_q <= regs_d;
    end
  end
endmodule

// File: rtl/cbc_rom_map.sv
module cbc_rom_map
  import cbc_pkg::*;
(
  input  logic [CPU_AW-1:0] addr,
  input  logic              hit_rom_lo,
  input  logic              hit_rom_hi,
  input  bank_regs_t        regs,
  input  logic [BANK_W-1:0] mask,
  output logic [ROM_AW-1:0] rom_addr
);
  logic [BANK_W-1:0] bank;

  always_comb begin
    bank = '0;
    if (hit_rom_lo && regs.mode) bank = low_window_bank(regs.sec, mask);
    else if (hit_rom_hi)         bank = high_window_bank(regs.sec, regs.pri, mask);
  end

  assign rom_addr = (hit_rom_lo || hit_rom_hi) ? {bank, addr[OFS_W-1:0]} : '0;
endmodule

// File: rtl/cbc_ram_map.sv
module cbc_ram_map
  import cbc_pkg::*;
(
  input  logic [CPU_AW-1:0] addr,
  input  bank_regs_t        regs,
  input  logic [1:0]        ram_size,
  output logic [RAM_AW-1:0] ram_addr
);
  logic [RAM_OFS_W-1:0] ofs;
  logic                 banked;
  assign ofs = addr[RAM_OFS_W-1:0];

  generate
    if (RAM_AW > RAM_OFS_W) begin : g_banked
      assign banked = (ram_cfg_e'(ram_size) == RAM_32K) && regs.mode;
      assign ram_addr = banked ? {regs.sec, ofs} : {{SEC_W{1'b0}}, ofs};
    end else begin : g_flat
      assign banked   = 1'b0;
      assign ram_addr = ofs;
    end
  endgenerate
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_wr,
  input  logic [DW-1:0]     rom_rdata,
  input  logic [DW-1:0]     ram_rdata,
  input  logic [LOG2_W-1:0] cfg_rom_log2,
  input  logic [1:0]        cfg_ram_size,
  output logic [DW-1:0]     cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we
);
  localparam logic [DW-1:0] FLOAT_BYTE = '1;

  logic hit_en, hit_pri, hit_sec, hit_mode, hit_rom_lo, hit_rom_hi, hit_ram;
  logic [BANK_W-1:0] rom_mask_w;
  bank_regs_t        regs_q;
  logic              ram_open;

  assign rom_mask_w = rom_mask(cfg_rom_log2);

  cbc_decode u_dec (
    .addr(cpu_addr), .hit_en(hit_en), .hit_pri(hit_pri), .hit_sec(hit_sec),
    .hit_mode(hit_mode), .hit_rom_lo(hit_rom_lo), .hit_rom_hi(hit_rom_hi),
    .hit_ram(hit_ram)
  );

  cbc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .hit_en(hit_en), .hit_pri(hit_pri),
    .hit_sec(hit_sec), .hit_mode(hit_mode), .wdata(cpu_wdata),
    .mask(rom_mask_w), .regs_q(regs_q)
  );

  cbc_rom_map u_rom (
    .addr(cpu_addr), .hit_rom_lo(hit_rom_lo), .hit_rom_hi(hit_rom_hi),
    .regs(regs_q), .mask(rom_mask_w), .rom_addr(rom_addr)
  );

  cbc_ram_map u_ram (
    .addr(cpu_addr), .regs(regs_q), .ram_size(cfg_ram_size), .ram_addr(ram_addr)
  );

  assign ram_open = hit_ram && regs_q.ram_en;
  assign ram_we   = ram_open && cpu_wr;

  always_comb begin
    if (hit_ram) cpu_rdata = regs_q.ram_en ? ram_rdata : FLOAT_BYTE;
    else         cpu_rdata = rom_rdata;
  end
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk
  import cbc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic [DW-1:0]     cpu_wdata,
  input logic              cpu_wr,
  input logic [DW-1:0]     cpu_rdata,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_we,
  input logic [1:0]        cfg_ram_size,
  input bank_regs_t        regs,
  input logic [BANK_W-1:0] mask
);
  logic wr_en_reg, wr_pri_reg, wr_sec_reg, wr_mode_reg, in_ram;
  assign wr_en_reg   = cpu_wr && (cpu_addr[15:13] == 3'd0);
  assign wr_pri_reg  = cpu_wr && (cpu_addr[15:13] == 3'd1);
  assign wr_sec_reg  = cpu_wr && (cpu_addr[15:13] == 3'd2);
  assign wr_mode_reg = cpu_wr && (cpu_addr[15:13] == 3'd3);
  assign in_ram      = (cpu_addr[15:13] == 3'd5);

  p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_reg |=> (regs.ram_en == ($past(cpu_wdata[3:0]) == 4'hA)));

  p_pri_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pri_reg && cpu_wdata[4:0] == 5'd0) |=> (regs.pri == 5'd1));

  p_pri_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pri_reg && cpu_wdata[4:0] != 5'd0) |=>
      (regs.pri == ($past(cpu_wdata[4:0]) & $past(mask[4:0]))));

  p_sec_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sec_reg |=> (regs.sec == $past(cpu_wdata[1:0])));

  p_mode_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode_reg |=> (regs.mode == $past(cpu_wdata[0])));

  p_bank_in_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15] == 1'b0) |-> ((rom_addr[ROM_AW-1:OFS_W] & ~mask) == '0));

  p_rom_lo_flat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00 && !regs.mode) |-> (rom_addr == {7'd0, cpu_addr[13:0]}));

  p_rom_hi_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b01) |-> (rom_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]));

  p_ram_we_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (regs.ram_en && in_ram && cpu_wr));

  p_ram_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ram && !regs.ram_en) |-> (cpu_rdata == 8'hFF));

  p_small_ram_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ram && cfg_ram_size != 2'd2) |-> (ram_addr[RAM_AW-1:RAM_OFS_W] == '0));

  p_regs_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr || cpu_addr[15]) |=> $stable(regs));
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .rom_addr(rom_addr),
  .ram_addr(ram_addr), .ram_we(ram_we), .cfg_ram_size(cfg_ram_size),
  .regs(regs_q), .mask(rom_mask_w)
);

// File: tb/cart_bank_ctrl_tb_top.sv
module cart_bank_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;
  localparam logic [1:0] K_WR = 2'd0, K_ROM = 2'd1, K_RAM = 2'd2;

  // {kind, cpu address, write byte, expected address}
  // configuration: 128 ROM banks, 32 KiB RAM
  localparam logic [46:0] VEC [NVEC] = '{
    {K_WR,  16'h2000, 8'h05, 21'h0},
    {K_ROM, 16'h4123, 8'h00, 21'h014123},
    {K_WR,  16'h4000, 8'h02, 21'h0},
    {K_ROM, 16'h4123, 8'h00, 21'h114123},
    {K_ROM, 16'h0123, 8'h00, 21'h000123},
    {K_WR,  16'h6000, 8'h01, 21'h0},
    {K_ROM, 16'h0123, 8'h00, 21'h100123},
    {K_RAM, 16'hA456, 8'h00, 21'h004456},
    {K_WR,  16'h2000, 8'h00, 21'h0},
    {K_ROM, 16'h7FFF, 8'h00, 21'h107FFF},
    {K_WR,  16'h2000, 8'h20, 21'h0},
    {K_ROM, 16'h7FFF, 8'h00, 21'h107FFF},
    {K_WR,  16'h2000, 8'hFF, 21'h0},
    {K_ROM, 16'h4000, 8'h00, 21'h17C000},
    {K_WR,  16'h6000, 8'hFE, 21'h0},
    {K_RAM, 16'hBFFF, 8'h00, 21'h001FFF},
    {K_ROM, 16'h3FFF, 8'h00, 21'h003FFF},
    {K_WR,  16'h4000, 8'h07, 21'h0},
    {K_RAM, 16'hA000, 8'h00, 21'h000000},
    {K_ROM, 16'h4000, 8'h00, 21'h1FC000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  rom_rdata = 8'h77;
  logic [7:0]  ram_rdata = 8'h5A;
  logic [2:0]  cfg_rom_log2 = 3'd7;
  logic [1:0]  cfg_ram_size = 2'd2;
  logic [7:0]  cpu_rdata;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        ram_we;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .cfg_rom_log2(cfg_rom_log2), .cfg_ram_size(cfg_ram_size),
    .cpu_rdata(cpu_rdata), .rom_addr(rom_addr), .ram_addr(ram_addr),
    .ram_we(ram_we)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic look(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    look(16'h4000); check("R1 rom bank after reset", rom_addr, 21'h004000);
    look(16'hA010); check("R1 ram disabled after reset", cpu_rdata, 8'hFF);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  k;
      logic [15:0] a;
      logic [7:0]  d;
      logic [20:0] e;
      {k, a, d, e} = VEC[i];
      if (k == K_WR) wr(a, d);
      else if (k == K_ROM) begin
        look(a); check($sformatf("R3_R6_R7 vec %0d rom_addr", i), rom_addr, e);
      end else begin
        look(a); check($sformatf("R9 vec %0d ram_addr", i), ram_addr, e);
      end
    end

    // R11: writes at or above 0x8000 leave banking untouched
    wr(16'hA000, 8'h00);
    wr(16'h8000, 8'h00);
    look(16'h4000); check("R11 regs kept after high writes", rom_addr, 21'h1FC000);
    rom_rdata = 8'h77;
    look(16'h4000); check("R11 rom data routed", cpu_rdata, 8'h77);

    // R5: 4-bank ROM masks stored state
    cfg_rom_log2 = 3'd2;
    look(16'h4000); check("R5 mask applied to high bank", rom_addr, 21'h00C000);
    // R3: raw zero test before mask -> bank 0
    wr(16'h2000, 8'h04);
    look(16'h4001); check("R3 masked-to-zero bank", rom_addr, 21'h000001);
    wr(16'h2000, 8'h00);
    look(16'h4001); check("R3 zero write gives bank 1", rom_addr, 21'h004001);
    // R6: mode 1, secondary 3, mask 3 -> low bank 0
    wr(16'h6000, 8'h01);
    look(16'h0010); check("R6 low bank masked out", rom_addr, 21'h000010);
    cfg_rom_log2 = 3'd6;
    look(16'h0010); check("R6 low bank with 64 banks", rom_addr, 21'h080010);

    // R8 gating
    ram_rdata = 8'h5A;
    look(16'hA000); check("R8 disabled read floats", cpu_rdata, 8'hFF);
    @(negedge clk); cpu_addr = 16'hA000; cpu_wr = 1'b1; #1;
    check("R8 disabled write dropped", ram_we, 1'b0);
    @(negedge clk); cpu_wr = 1'b0;
    wr(16'h0000, 8'h0A);
    look(16'hA000); check("R2 enabled read data", cpu_rdata, 8'h5A);
    @(negedge clk); cpu_addr = 16'hA001; cpu_wr = 1'b1; #1;
    check("R8 enabled write strobe", ram_we, 1'b1);
    @(negedge clk); cpu_wr = 1'b0;
    wr(16'h1FFF, 8'h1A);
    look(16'hA000); check("R2 upper nibble ignored", cpu_rdata, 8'h5A);
    wr(16'h0000, 8'h0B);
    look(16'hA000); check("R2 other value disables", cpu_rdata, 8'hFF);

    // R10 / R9 RAM sizes, mode 1, secondary 3
    cfg_ram_size = 2'd1;
    look(16'hB234); check("R10 8K ram wraps", ram_addr, 15'h1234);
    cfg_ram_size = 2'd0;
    look(16'hB234); check("R10 no ram wraps", ram_addr, 15'h1234);
    cfg_ram_size = 2'd2;
    look(16'hB234); check("R9 32K banked", ram_addr, 15'h7234);

    // R1 reset mid-run
    do_reset();
    look(16'h4000); check("R1 primary back to 1", rom_addr, 21'h004000);
    look(16'h0010); check("R1 mode back to 0", rom_addr, 21'h000010);
    look(16'hB234); check("R1 secondary ignored in mode 0", ram_addr, 15'h1234);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule